// File: doc/BRIEF.md
# Decimal Floating-Point Adder/Subtracter

This block adds or subtracts two 128-bit decimal floating-point numbers. Each word carries a 27-digit packed-BCD significand, a four-digit BCD exponent magnitude (a power of ten), and four flag bits. The flags are the exponent sign, an infinity marker, the number's sign and a not-a-number marker. The result is truncated toward zero, has its leading digit normalized, and uses the same format.

A caller presents both operands and the operation select, then pulses `start` for one cycle while the block is idle. The block then runs through a short state machine:

- `ST_IDLE` moves to `ST_ALIGN` on `start` and latches the inputs.
- `ST_ALIGN` moves to `ST_DONE` when a special value decides the outcome, and to `ST_ARITH` otherwise. On the way to `ST_ARITH` it shifts the operand with the smaller exponent.
- `ST_ARITH` always moves to `ST_NORM`. It performs one BCD addition, or one nines-complement subtraction.
- `ST_NORM` loops on itself once per digit shift. It moves to `ST_DONE` when no further shift applies.
- `ST_DONE` raises `done` for one cycle and returns to `ST_IDLE`.

The result stays on `result` until the next operation writes a new one.

Top module: `dfp_addsub`

## Requirements
- R1: Word layout, from the most significant bit down:
  - bit 127: exponent sign (1 = negative);
  - bit 126: infinity;
  - bit 125: sign;
  - bit 124: NaN;
  - bits 123:108: exponent magnitude as four BCD digits;
  - bits 107:0: the significand as 27 BCD digits, with digit 0 in bits 3:0.

  A finite result is packed in this same layout.
- R2: When exponents differ, the significand of the operand with the smaller exponent is shifted right one digit for each unit of difference, and the result takes the larger exponent. A difference of 27 or more makes that operand contribute zero.
- R3: Significand addition applies decimal carry correction in every digit, so every result digit lies in 0..9.
- R4: The effective operation is a subtraction when the sign of A differs from the sign of B XOR `op_sub`. In that case the smaller aligned magnitude is taken from the larger one. The result takes the effective sign of the larger operand (A's sign when the magnitudes are equal).
- R5: A carry out of digit 26 shifts the significand right by one digit, dropping the lowest digit, and raises the exponent by one.
- R6: A nonzero result is shifted left, one digit and one exponent step at a time, until digit 26 is nonzero or the exponent reaches -9999.
- R7: A result whose significand is exactly zero is returned as all 128 bits zero.
- R8: A NaN in either operand gives a canonical NaN. So does the sum of two infinities whose effective signs differ. The canonical NaN has only bit 124 set.
- R9: Otherwise, an infinite operand gives an infinity with that operand's effective sign (B's sign XOR `op_sub` for B). Only bit 126 and the sign bit may be set.
- R10: A finite result whose exponent would exceed +9999 becomes an infinity with the result's sign.
- R11: `start` is sampled only in the idle state. `done` is high for exactly one cycle per operation, and `result` holds its value after that. A `start` given while an operation is in progress is ignored.
- R12: After reset, `done` is low and `result` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to begin an operation |
| op_sub | input | 1 | 1 = A minus B, 0 = A plus B |
| opnd_a | input | 128 | Operand A |
| opnd_b | input | 128 | Operand B |
| result | output | 128 | Sum or difference, held until the next operation completes |
| done | output | 1 | One-cycle strobe marking `result` as new |

## Verification
The assertions on result digits and on canonical zero and special encodings assume both operands hold only legal BCD digits (0..9) in their significand and exponent fields. They also assume that NaN and infinity are never both set in an operand. Every vector in the bench is built from hexadecimal literals whose nibbles are decimal digits, and each operand sets at most one of those two flags. Requests are only issued while the block is idle, except in the one directed case that deliberately pulses `start` during an operation.

// File: rtl/dfp_pkg.sv
package dfp_pkg;

    // Controller states of the decimal adder/subtracter.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ALIGN,
        ST_ARITH,
        ST_NORM,
        ST_DONE
    } dfp_state_e;

endpackage

// File: rtl/dfp_unpack.sv
module dfp_unpack #(
    parameter int DIGITS  = 27,
    parameter int EDIGITS = 4,
    localparam int SW  = 4 * DIGITS,
    localparam int EW  = 4 * EDIGITS,
    localparam int W   = SW + EW + 4,
    localparam int EBW = EW + 2
) (
    input  logic [W-1:0]          word,
    output logic [SW-1:0]         sig,
    output logic signed [EBW-1:0] expo,
    output logic                  sign,
    output logic                  nan,
    output logic                  inf
);

    // The BCD exponent magnitude becomes a signed binary exponent.
    always_comb begin
        int acc;
        acc = 0;
        for (int i = EDIGITS - 1; i >= 0; i--) begin
            acc = acc * 10 + int'(word[SW + 4*i +: 4]);
        end
        expo = word[W-1] ? -EBW'(acc) : EBW'(acc);
    end

    assign sig  = word[SW-1:0];
    assign nan  = word[W-4];
    assign sign = word[W-3];
    assign inf  = word[W-2];

endmodule

// File: rtl/dfp_bcd_addsub.sv
module dfp_bcd_addsub #(
    parameter int DIGITS = 27,
    localparam int SW = 4 * DIGITS
) (
    input  logic [SW-1:0] x,
    input  logic [SW-1:0] y,
    input  logic          sub,
    output logic [SW+3:0] sum
);

    // Ripple of decimal digit cells. For subtraction, y enters as its
    // nines complement with an initial carry of one.
    logic [DIGITS:0] cy;
    assign cy[0] = sub;

    for (genvar g = 0; g < DIGITS; g++) begin : g_digit
        logic [3:0] yd;
        logic [4:0] raw;
        assign yd  = sub ? (4'd9 - y[4*g +: 4]) : y[4*g +: 4];
        assign raw = {1'b0, x[4*g +: 4]} + {1'b0, yd} + {4'b0, cy[g]};
        assign cy[g+1] = (raw > 5'd9);
        assign sum[4*g +: 4] = cy[g+1] ? 4'(raw - 5'd10) : raw[3:0];
    end

    // Carry digit only matters for addition; a subtraction carry is discarded.
    assign sum[SW+3:SW] = (!sub && cy[DIGITS]) ? 4'd1 : 4'd0;

endmodule

// File: rtl/dfp_addsub.sv
module dfp_addsub
    import dfp_pkg::*;
#(
    parameter int DIGITS  = 27,
    parameter int EDIGITS = 4,
    localparam int SW  = 4 * DIGITS,
    localparam int EW  = 4 * EDIGITS,
    localparam int W   = SW + EW + 4,
    localparam int EBW = EW + 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         op_sub,
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    output logic [W-1:0] result,
    output logic         done
);

    localparam int EMAX = 10 ** EDIGITS - 1;
    localparam logic [EW-1:0] EMAX_BCD = {EDIGITS{4'h9}};
    localparam logic [W-1:0]  NAN_WORD = W'(1) << (W - 4);

    dfp_state_e state, nxt;

    logic [W-1:0]          lat_a, lat_b, res;
    logic                  lat_sub;
    logic [SW-1:0]         p_sig, q_sig;
    logic signed [EBW-1:0] r_exp;
    logic                  r_sign;
    logic [SW+3:0]         acc;

    // Field extraction of the latched operands
    logic [SW-1:0]         a_sig, b_sig;
    logic signed [EBW-1:0] a_exp, b_exp;
    logic                  a_sgn, b_sgn, a_nan, b_nan, a_inf, b_inf;

    dfp_unpack #(.DIGITS(DIGITS), .EDIGITS(EDIGITS)) u_unp_a (
        .word(lat_a), .sig(a_sig), .expo(a_exp), .sign(a_sgn), .nan(a_nan), .inf(a_inf));
    dfp_unpack #(.DIGITS(DIGITS), .EDIGITS(EDIGITS)) u_unp_b (
        .word(lat_b), .sig(b_sig), .expo(b_exp), .sign(b_sgn), .nan(b_nan), .inf(b_inf));

    logic b_eff, esub;
    assign b_eff = b_sgn ^ lat_sub;
    assign esub  = a_sgn ^ b_eff;

    // Special-value decisions
    logic nan_case, inf_case, inf_sign;
    assign nan_case = a_nan | b_nan | (a_inf & b_inf & (a_sgn != b_eff));
    assign inf_case = a_inf | b_inf;
    assign inf_sign = a_inf ? a_sgn : b_eff;

    function automatic logic [W-1:0] inf_word(input logic s);
        return {1'b0, 1'b1, s, 1'b0, {(EW+SW){1'b0}}};
    endfunction

    // Digit-granular right shift; 27 digits or more empties the significand.
    function automatic logic [SW-1:0] dshr(input logic [SW-1:0] s,
                                           input logic signed [EBW:0] amt);
        if (amt >= (EBW+1)'(DIGITS)) return '0;
        return s >> (4 * int'(amt));
    endfunction

    // Alignment
    logic signed [EBW:0]   diff;
    logic [SW-1:0]         a_al, b_al;
    logic signed [EBW-1:0] top_exp;
    always_comb begin
        diff    = (EBW+1)'(a_exp) - (EBW+1)'(b_exp);
        a_al    = (diff < 0) ? dshr(a_sig, -diff) : a_sig;
        b_al    = (diff > 0) ? dshr(b_sig, diff) : b_sig;
        top_exp = (diff < 0) ? b_exp : a_exp;
    end

    // Significand arithmetic: the larger magnitude goes first when subtracting.
    logic          swap;
    logic [SW-1:0] add_x, add_y;
    logic [SW+3:0] add_sum;
    logic          add_sign;
    assign swap     = esub && (p_sig < q_sig);
    assign add_x    = swap ? q_sig : p_sig;
    assign add_y    = swap ? p_sig : q_sig;
    assign add_sign = swap ? b_eff : a_sgn;

    dfp_bcd_addsub #(.DIGITS(DIGITS)) u_bcd (
        .x(add_x), .y(add_y), .sub(esub), .sum(add_sum));

    // Normalization conditions
    logic [3:0] carry_dig, top_dig;
    logic       can_left, norm_busy;
    assign carry_dig = acc[SW+3:SW];
    assign top_dig   = acc[SW-1:SW-4];
    assign can_left  = (top_dig == 4'd0) && (acc != '0) && (r_exp > EBW'(-EMAX));
    assign norm_busy = (carry_dig != 4'd0) || can_left;

    // Packing of a finite result
    logic [W-1:0] pack_word;
    always_comb begin
        int m;
        logic [EW-1:0] bcd;
        m = (r_exp < 0) ? -int'(r_exp) : int'(r_exp);
        for (int i = 0; i < EDIGITS; i++) begin
            bcd[4*i +: 4] = 4'(m % 10);
            m = m / 10;
        end
        pack_word = {r_exp < 0, 1'b0, r_sign, 1'b0, bcd, acc[SW-1:0]};
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (start) nxt = ST_ALIGN;
            ST_ALIGN: nxt = (nan_case || inf_case) ? ST_DONE : ST_ARITH;
            ST_ARITH: nxt = ST_NORM;
            ST_NORM:  if (!norm_busy) nxt = ST_DONE;
            ST_DONE:  nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_a   <= '0;
            lat_b   <= '0;
            lat_sub <= 1'b0;
            p_sig   <= '0;
            q_sig   <= '0;
            r_exp   <= '0;
            r_sign  <= 1'b0;
            acc     <= '0;
            res     <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    lat_a   <= opnd_a;
                    lat_b   <= opnd_b;
                    lat_sub <= op_sub;
                end
                ST_ALIGN: begin
                    if (nan_case)      res <= NAN_WORD;
                    else if (inf_case) res <= inf_word(inf_sign);
                    else begin
                        p_sig <= a_al;
                        q_sig <= b_al;
                        r_exp <= top_exp;
                    end
                end
                ST_ARITH: begin
                    acc    <= add_sum;
                    r_sign <= add_sign;
                end
                ST_NORM: begin
                    if (carry_dig != 4'd0) begin
                        acc   <= acc >> 4;
                        r_exp <= r_exp + EBW'(1);
                    end else if (can_left) begin
                        acc   <= {4'b0, acc[SW-5:0], 4'b0};
                        r_exp <= r_exp - EBW'(1);
                    end else if (acc == '0) begin
                        res <= '0;
                    end else if (r_exp > EBW'(EMAX)) begin
                        res <= inf_word(r_sign);
                    end else begin
                        res <= pack_word;
                    end
                end
                ST_DONE: ;
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        done   = (state == ST_DONE);
        result = res;
    end

    function automatic logic digits_ok(input logic [SW-1:0] s);
        for (int i = 0; i < DIGITS; i++) begin
            if (s[4*i +: 4] > 4'd9) return 1'b0;
        end
        return 1'b1;
    endfunction

    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r11_busy_ignores_start: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> $stable(lat_a) && $stable(lat_b));

    a_r5_carry_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_NORM && carry_dig != 4'd0) |=> (acc[SW+3:SW] == 4'd0));

    a_r3_digits_legal: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> digits_ok(result[SW-1:0]));

    a_r7_zero_canonical: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result[SW-1:0] == '0 && !result[W-4] && !result[W-2])
            |-> (result[W-1:SW] == '0));

    a_r6_normalized: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !result[W-4] && !result[W-2] && result[SW-1:0] != '0
              && result[SW-1:SW-4] == 4'd0)
            |-> (result[W-1] && result[SW+EW-1:SW] == EMAX_BCD));

    a_r8_special_fields: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (result[W-4] || result[W-2]))
            |-> (result[SW+EW-1:0] == '0 && !(result[W-4] && result[W-2])));

endmodule

// File: tb/sim_dfp_addsub.sv
module sim_dfp_addsub;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         op_sub = 1'b0;
    logic [127:0] opnd_a = '0;
    logic [127:0] opnd_b = '0;
    logic [127:0] result;
    logic         done;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    dfp_addsub u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .op_sub(op_sub),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result), .done(done));

    // flags nibble: 8 = exponent sign, 4 = infinity, 2 = sign, 1 = NaN
    function automatic logic [127:0] mk(input logic [3:0] fl, input logic [15:0] e,
                                        input logic [107:0] s);
        return {fl, e, s};
    endfunction

    typedef struct packed {
        logic         sub;
        logic [3:0]   req;
        logic [127:0] a;
        logic [127:0] b;
        logic [127:0] exp;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        // R6: 1 + 1 normalizes left by 26 digits
        '{1'b0, 4'd6, mk(4'h0, 16'h0000, 108'h1), mk(4'h0, 16'h0000, 108'h1),
          mk(4'h8, 16'h0026, 108'h2 << 104)},
        // R5: carry out of the top digit
        '{1'b0, 4'd5, mk(4'h0, 16'h0000, 108'h5 << 104), mk(4'h0, 16'h0000, 108'h5 << 104),
          mk(4'h0, 16'h0001, 108'h1 << 104)},
        // R4: 3 - 5 gives negative
        '{1'b1, 4'd4, mk(4'h0, 16'h0000, 108'h3 << 104), mk(4'h0, 16'h0000, 108'h5 << 104),
          mk(4'h2, 16'h0000, 108'h2 << 104)},
        // R7: x - x is positive zero
        '{1'b1, 4'd7, mk(4'h0, 16'h0005, 108'h7 << 104), mk(4'h0, 16'h0005, 108'h7 << 104),
          128'h0},
        // R2: exponent difference of two
        '{1'b0, 4'd2, mk(4'h0, 16'h0002, 108'h1 << 104), mk(4'h0, 16'h0000, 108'h1 << 104),
          mk(4'h0, 16'h0002, (108'h1 << 104) | (108'h1 << 96))},
        // R2: difference of 30 drops the smaller operand
        '{1'b0, 4'd2, mk(4'h0, 16'h0030, 108'h1 << 104), mk(4'h0, 16'h0000, 108'h9 << 104),
          mk(4'h0, 16'h0030, 108'h1 << 104)},
        // R2: negative exponent operand is the one shifted
        '{1'b0, 4'd2, mk(4'h8, 16'h0001, 108'h1 << 104), mk(4'h0, 16'h0000, 108'h1 << 104),
          mk(4'h0, 16'h0000, (108'h1 << 104) | (108'h1 << 100))},
        // R3: decimal carry 9 + 1
        '{1'b0, 4'd3, mk(4'h0, 16'h0000, 108'h19 << 100), mk(4'h0, 16'h0000, 108'h1 << 100),
          mk(4'h0, 16'h0000, 108'h2 << 104)},
        // R4: decimal borrow 20 - 01
        '{1'b1, 4'd4, mk(4'h0, 16'h0000, 108'h2 << 104), mk(4'h0, 16'h0000, 108'h1 << 100),
          mk(4'h0, 16'h0000, 108'h19 << 100)},
        // R6: 10 - 9 normalizes left by one digit
        '{1'b1, 4'd6, mk(4'h0, 16'h0000, 108'h1 << 104), mk(4'h0, 16'h0000, 108'h9 << 100),
          mk(4'h8, 16'h0001, 108'h1 << 104)},
        // R4: -5 + 3
        '{1'b0, 4'd4, mk(4'h2, 16'h0000, 108'h5 << 104), mk(4'h0, 16'h0000, 108'h3 << 104),
          mk(4'h2, 16'h0000, 108'h2 << 104)},
        // R4: 1 - (-1) becomes an addition
        '{1'b1, 4'd4, mk(4'h0, 16'h0000, 108'h1 << 104), mk(4'h2, 16'h0000, 108'h1 << 104),
          mk(4'h0, 16'h0000, 108'h2 << 104)},
        // R8: NaN operand
        '{1'b0, 4'd8, mk(4'h1, 16'h0000, 108'h0), mk(4'h0, 16'h0000, 108'h1 << 104),
          128'h1 << 124},
        // R8: +inf + -inf
        '{1'b0, 4'd8, mk(4'h4, 16'h0000, 108'h0), mk(4'h6, 16'h0000, 108'h0),
          128'h1 << 124},
        // R8: +inf - +inf
        '{1'b1, 4'd8, mk(4'h4, 16'h0000, 108'h0), mk(4'h4, 16'h0000, 108'h0),
          128'h1 << 124},
        // R9: 1 - +inf gives -inf
        '{1'b1, 4'd9, mk(4'h0, 16'h0000, 108'h1 << 104), mk(4'h4, 16'h0000, 108'h0),
          mk(4'h6, 16'h0000, 108'h0)},
        // R9: -inf + 5 gives -inf
        '{1'b0, 4'd9, mk(4'h6, 16'h0000, 108'h0), mk(4'h0, 16'h0000, 108'h5 << 104),
          mk(4'h6, 16'h0000, 108'h0)},
        // R10: exponent overflow
        '{1'b0, 4'd10, mk(4'h0, 16'h9999, 108'h5 << 104), mk(4'h0, 16'h9999, 108'h5 << 104),
          mk(4'h4, 16'h0000, 108'h0)},
        // R6: minimum exponent stops normalization
        '{1'b0, 4'd6, mk(4'h8, 16'h9999, 108'h1), mk(4'h8, 16'h9999, 108'h1),
          mk(4'h8, 16'h9999, 108'h2)},
        // R1: multi-digit sum with carries, exponent kept
        '{1'b0, 4'd1, mk(4'h0, 16'h0123, 108'h123456789 << 72),
          mk(4'h0, 16'h0123, 108'h111111111 << 72),
          mk(4'h0, 16'h0123, 108'h234567900 << 72)},
        // R7: -3 + 3 is positive zero
        '{1'b0, 4'd7, mk(4'h2, 16'h0000, 108'h3 << 104), mk(4'h0, 16'h0000, 108'h3 << 104),
          128'h0},
        // R2: difference of exactly 27
        '{1'b0, 4'd2, mk(4'h0, 16'h0027, 108'h1 << 104), mk(4'h0, 16'h0000, 108'h9 << 104),
          mk(4'h0, 16'h0027, 108'h1 << 104)}
    };

    task automatic check(input int req, input logic [127:0] got, input logic [127:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL R%0d: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic run(input logic s, input logic [127:0] a, input logic [127:0] b,
                       output logic [127:0] r, output logic seen);
        @(negedge clk);
        opnd_a = a; opnd_b = b; op_sub = s; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        seen = 1'b0;
        for (int k = 0; k < 200; k++) begin
            if (done) begin seen = 1'b1; break; end
            @(negedge clk);
        end
        r = result;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [127:0] r;
        logic         seen;

        // R12: reset state
        repeat (3) @(negedge clk);
        check(12, {127'b0, done}, 128'h0);
        check(12, result, 128'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            run(VECS[i].sub, VECS[i].a, VECS[i].b, r, seen);
            check(11, {127'b0, seen}, 128'h1);
            check(int'(VECS[i].req), r, VECS[i].exp);
        end

        // R11: done lasts one cycle and result is held afterwards
        @(negedge clk);
        check(11, {127'b0, done}, 128'h0);
        check(11, result, VECS[NV-1].exp);

        // R11: a start while busy is ignored
        @(negedge clk);
        opnd_a = VECS[0].a; opnd_b = VECS[0].b; op_sub = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (2) @(negedge clk);
        opnd_a = mk(4'h1, 16'h0000, 108'h0); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        seen = 1'b0;
        for (int k = 0; k < 200; k++) begin
            if (done) begin seen = 1'b1; break; end
            @(negedge clk);
        end
        check(11, {127'b0, seen}, 128'h1);
        check(11, result, VECS[0].exp);
        @(negedge clk);
        check(11, {127'b0, done}, 128'h0);
        repeat (3) @(negedge clk);
        check(11, {127'b0, done}, 128'h0);
        check(11, result, VECS[0].exp);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule